// File: doc/BRIEF.md
# Bounded Transactional Line Tracker

This block lets a core update several cache lines as one atomic step. Software first issues marked loads, and each one registers a line address in a small tracking set. An acquire command then opens the region and records two pointer values: the instruction pointer and the stack pointer. While the region is open, stores may target only registered lines. Their data is held in the tracker and is not visible outside it.

A commit streams the buffered lines out, one per cycle, in the order the lines were registered. Several events abort the region and discard the buffered data: an explicit abort, a stray store, too many lines, or a remote write that hits a tracked line. On abort the block pulses an abort flag with a reason code and returns the saved pointer pair.

Addresses are compared at line granularity. The low six bits select a byte inside a 64-byte line and take no part in matching.

Top module: `txn_line_tracker`

## Requirements
- R1: Up to NUM_LINES (default 8) distinct lines can be registered. A marked load of a line that is already registered does not use a slot. A marked load of a new line when all slots are full aborts with code 1 (capacity).
- R2: Line addresses are compared on addr[ADDR_W-1:6] for marked loads, stores and snoops. Write-out addresses have their low six bits at zero.
- R3: A snoop (remote write) that matches a registered line before the region is open marks that line as disturbed. The next acquire then aborts with code 3 (disturbed) and the region stays closed. A snoop in the same cycle as the acquire has the same effect.
- R4: abort_valid is high for exactly one cycle, in the cycle after the aborting event, and abort_code is valid with it. For an abort while the region is open, rb_ip/rb_sp carry the pointers captured at acquire. For a disturbed acquire, they carry the pointers presented with that acquire. For any other abort while the region is closed, they are zero.
- R5: A store to a registered line in an open region buffers its data; a later store to the same line replaces it. A store to an unregistered line, or a store while no region is open, aborts with code 4 (stray store).
- R6: A snoop that matches a registered line while the region is open aborts with code 2 (conflict). This takes priority over any command in the same cycle, including a commit.
- R7: An abort command aborts with code 5 (user). Any abort discards all registered lines and all buffered data, so a later region starts empty and a commit of it writes nothing.
- R8: After a commit, starting the next cycle, the block visits one registered entry per cycle in registration order. wr_valid is high only for entries that hold stored data, with that line's address and last data. After the last entry, the tracker is empty and closed.
- R9: Commands and snoops that arrive during the commit write-out are ignored: no abort is raised and the write-out continues.
- R10: After reset, no region is open, no write-out or abort is signalled, and no line is registered.

Command encoding on cmd_op: 0 none, 1 marked load, 2 acquire, 3 speculative store, 4 commit, 5 abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | ADDR_W | Byte address for a marked load or store |
| cmd_data | input | DATA_W | Store data |
| cmd_ip | input | PTR_W | Instruction pointer captured on acquire |
| cmd_sp | input | PTR_W | Stack pointer captured on acquire |
| snp_valid | input | 1 | Remote write snoop present |
| snp_addr | input | ADDR_W | Snooped byte address |
| wr_valid | output | 1 | Committed line on write-out port |
| wr_addr | output | ADDR_W | Line-aligned write-out address |
| wr_data | output | DATA_W | Write-out line data |
| abort_valid | output | 1 | One-cycle abort pulse |
| abort_code | output | 3 | Abort reason |
| rb_ip | output | PTR_W | Rollback instruction pointer |
| rb_sp | output | PTR_W | Rollback stack pointer |
| region_open | output | 1 | Region acquired and running |
| draining | output | 1 | Commit write-out in progress |

## Verification
The bench uses the default parameters: eight slots, 64-byte lines, 32-bit addresses and 64-bit line data. With eight slots, filling the set and reaching the ninth-line capacity abort takes only a handful of commands. The 64-byte granularity lets the bench give the same line with different low bits, for duplicate registration, snoop hits and write-out alignment. A three-line commit, with one line left clean, shows both the ordered walk and the clean-entry gap, and a command is injected in the middle of that write-out.

// File: rtl/tlt_pkg.sv
// Shared encodings for the transactional line tracker.
// Assumes cmd_op values outside the listed commands behave as no-op.
package tlt_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_MARK   = 3'd1,
        OP_OPEN   = 3'd2,
        OP_STORE  = 3'd3,
        OP_COMMIT = 3'd4,
        OP_ABORT  = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        AB_NONE      = 3'd0,
        AB_CAPACITY  = 3'd1,
        AB_CONFLICT  = 3'd2,
        AB_DISTURBED = 3'd3,
        AB_STRAY     = 3'd4,
        AB_USER      = 3'd5
    } abort_e;

    typedef enum logic [1:0] {
        ST_MARK  = 2'd0,
        ST_OPEN  = 2'd1,
        ST_DRAIN = 2'd2
    } state_e;
endpackage

// File: rtl/tlt_cam.sv
// Parallel tag comparator: flags every valid entry whose line tag equals
// the probe tag. Assumes tags in the set are unique, so at most one bit is set.
module tlt_cam #(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 26
) (
    input  logic [TAG_W-1:0]     tags_i [NUM_LINES],
    input  logic [NUM_LINES-1:0] valid_i,
    input  logic [TAG_W-1:0]     probe_i,
    output logic [NUM_LINES-1:0] hit_o
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmp
        // per-entry equality against the probe
        assign hit_o[g] = valid_i[g] && (tags_i[g] == probe_i);
    end
endmodule

// File: rtl/tlt_entry_file.sv
// Storage for registered lines: tag, buffered data, and the stored and
// disturbed flags per entry. Entries fill in order from index 0. Assumes the
// caller raises alloc_i only when a slot is free and the tag is new.
module tlt_entry_file #(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 26,
    parameter int DATA_W    = 64,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int CNT_W    = $clog2(NUM_LINES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 alloc_i,
    input  logic [TAG_W-1:0]     alloc_tag_i,
    input  logic                 wr_i,
    input  logic [IDX_W-1:0]     wr_idx_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic                 disturb_i,
    input  logic [NUM_LINES-1:0] disturb_vec_i,
    output logic [TAG_W-1:0]     tags_o [NUM_LINES],
    output logic [DATA_W-1:0]    data_o [NUM_LINES],
    output logic [NUM_LINES-1:0] valid_o,
    output logic [NUM_LINES-1:0] dirty_o,
    output logic [NUM_LINES-1:0] disturbed_o,
    output logic [CNT_W-1:0]     count_o
);
    // entry flags and fill counter
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            valid_o     <= '0;
            dirty_o     <= '0;
            disturbed_o <= '0;
            count_o     <= '0;
        end else begin
            if (alloc_i) begin
                valid_o[count_o[IDX_W-1:0]] <= 1'b1;
                count_o <= count_o + 1'b1;
            end
            if (wr_i) begin
                dirty_o[wr_idx_i] <= 1'b1;
            end
            if (disturb_i) begin
                disturbed_o <= disturbed_o | (disturb_vec_i & valid_o);
            end
        end
    end

    // tag and data payload, no reset needed behind the valid bits
    always_ff @(posedge clk) begin
        if (alloc_i) begin
            tags_o[count_o[IDX_W-1:0]] <= alloc_tag_i;
        end
        if (wr_i) begin
            data_o[wr_idx_i] <= wr_data_i;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(NUM_LINES)); // R1
    AST_DIRTY_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_o & ~valid_o) == '0); // R5
endmodule

// File: rtl/txn_line_tracker.sv
// Bounded transactional line tracker. Registers lines with marked loads,
// opens a region on acquire (saving the instruction and stack pointers),
// buffers stores to registered lines, and either streams them out on commit
// or discards them on abort. Assumes one command per cycle and that the
// snoop port carries remote writes only.
module txn_line_tracker
    import tlt_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 32,
    parameter int OFS_W     = 6,
    parameter int DATA_W    = 64,
    parameter int PTR_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [PTR_W-1:0]  cmd_ip,
    input  logic [PTR_W-1:0]  cmd_sp,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              abort_valid,
    output logic [2:0]        abort_code,
    output logic [PTR_W-1:0]  rb_ip,
    output logic [PTR_W-1:0]  rb_sp,
    output logic              region_open,
    output logic              draining
);
    localparam int TAG_W = ADDR_W - OFS_W;
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int CNT_W = $clog2(NUM_LINES + 1);

    state_e              state_q;
    logic [IDX_W-1:0]    drain_idx_q;
    logic [PTR_W-1:0]    ckpt_ip_q, ckpt_sp_q;

    logic [TAG_W-1:0]     tags [NUM_LINES];
    logic [DATA_W-1:0]    data [NUM_LINES];
    logic [NUM_LINES-1:0] valid, dirty, disturbed, cmd_hit, snp_hit;
    logic [CNT_W-1:0]     count;
    logic [TAG_W-1:0]     cmd_tag, snp_tag;
    logic [IDX_W-1:0]     cmd_idx;
    logic                 cmd_any, snp_any, full, drain_last;
    logic                 do_abort, use_cmd_ptr, alloc, store, open_go, drain_go;
    logic                 disturb, clear_ent;
    abort_e               code_d;
    op_e                  op;
    logic                 unused_low;

    assign cmd_tag    = cmd_addr[ADDR_W-1:OFS_W];
    assign snp_tag    = snp_addr[ADDR_W-1:OFS_W];
    assign unused_low = ^{cmd_addr[OFS_W-1:0], snp_addr[OFS_W-1:0]};
    assign op         = op_e'(cmd_op);

    tlt_cam #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_cmd_cam (
        .tags_i(tags), .valid_i(valid), .probe_i(cmd_tag), .hit_o(cmd_hit));
    tlt_cam #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_snp_cam (
        .tags_i(tags), .valid_i(valid), .probe_i(snp_tag), .hit_o(snp_hit));

    tlt_entry_file #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_entries (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_ent),
        .alloc_i(alloc), .alloc_tag_i(cmd_tag),
        .wr_i(store), .wr_idx_i(cmd_idx), .wr_data_i(cmd_data),
        .disturb_i(disturb), .disturb_vec_i(snp_hit),
        .tags_o(tags), .data_o(data), .valid_o(valid), .dirty_o(dirty),
        .disturbed_o(disturbed), .count_o(count));

    // one-hot hit to index for the store path
    always_comb begin
        cmd_idx = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (cmd_hit[i]) cmd_idx = IDX_W'(i);
        end
    end

    assign cmd_any    = |cmd_hit;
    assign snp_any    = snp_valid && (|snp_hit);
    assign full       = (count == CNT_W'(NUM_LINES));
    assign drain_last = (state_q == ST_DRAIN) && ((CNT_W'(drain_idx_q) + 1'b1) == count);

    // command and snoop decision for the current cycle
    always_comb begin
        do_abort = 1'b0; use_cmd_ptr = 1'b0; code_d = AB_NONE;
        alloc = 1'b0; store = 1'b0; open_go = 1'b0; drain_go = 1'b0; disturb = 1'b0;
        unique case (state_q)
            ST_MARK: begin
                disturb = snp_any;
                unique case (op)
                    OP_MARK: if (!cmd_any) begin
                        if (full) begin do_abort = 1'b1; code_d = AB_CAPACITY; end
                        else alloc = 1'b1;
                    end
                    OP_OPEN: if ((|disturbed) || snp_any) begin
                        do_abort = 1'b1; code_d = AB_DISTURBED; use_cmd_ptr = 1'b1;
                    end else open_go = 1'b1;
                    OP_STORE: begin do_abort = 1'b1; code_d = AB_STRAY; end
                    OP_ABORT: begin do_abort = 1'b1; code_d = AB_USER; end
                    default: ;
                endcase
            end
            ST_OPEN: begin
                if (snp_any) begin
                    do_abort = 1'b1; code_d = AB_CONFLICT;
                end else begin
                    unique case (op)
                        OP_MARK: if (!cmd_any) begin
                            if (full) begin do_abort = 1'b1; code_d = AB_CAPACITY; end
                            else alloc = 1'b1;
                        end
                        OP_STORE: if (cmd_any) store = 1'b1;
                                  else begin do_abort = 1'b1; code_d = AB_STRAY; end
                        OP_COMMIT: drain_go = 1'b1;
                        OP_ABORT: begin do_abort = 1'b1; code_d = AB_USER; end
                        default: ;
                    endcase
                end
            end
            default: ;
        endcase
    end

    assign clear_ent = do_abort || drain_last || (drain_go && count == '0);

    // region state, drain pointer and checkpoint
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_MARK;
            drain_idx_q <= '0;
            ckpt_ip_q   <= '0;
            ckpt_sp_q   <= '0;
        end else begin
            if (do_abort || drain_last) state_q <= ST_MARK;
            else if (open_go)           state_q <= ST_OPEN;
            else if (drain_go)          state_q <= (count == '0) ? ST_MARK : ST_DRAIN;
            drain_idx_q <= drain_go ? '0 : (state_q == ST_DRAIN ? drain_idx_q + 1'b1 : drain_idx_q);
            if (open_go) begin
                ckpt_ip_q <= cmd_ip;
                ckpt_sp_q <= cmd_sp;
            end else if (clear_ent) begin
                ckpt_ip_q <= '0;
                ckpt_sp_q <= '0;
            end
        end
    end

    // abort pulse with reason and rollback pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_valid <= 1'b0;
            abort_code  <= AB_NONE;
            rb_ip       <= '0;
            rb_sp       <= '0;
        end else begin
            abort_valid <= do_abort;
            abort_code  <= do_abort ? code_d : AB_NONE;
            rb_ip       <= !do_abort ? '0 : (use_cmd_ptr ? cmd_ip : ckpt_ip_q);
            rb_sp       <= !do_abort ? '0 : (use_cmd_ptr ? cmd_sp : ckpt_sp_q);
        end
    end

    assign wr_valid    = (state_q == ST_DRAIN) && dirty[drain_idx_q];
    assign wr_addr     = {tags[drain_idx_q], {OFS_W{1'b0}}};
    assign wr_data     = data[drain_idx_q];
    assign region_open = (state_q == ST_OPEN);
    assign draining    = (state_q == ST_DRAIN);

    AST_OPEN_UNDISTURBED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN) |-> (disturbed == '0)); // R3
    AST_ABORT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        abort_valid |-> (valid == '0)); // R7
    AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && $past(state_q) == ST_DRAIN) |-> drain_idx_q == $past(drain_idx_q) + 1'b1); // R8
    AST_DRAIN_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |=> !abort_valid); // R9
endmodule

// File: tb/txn_line_tracker_test.sv
`timescale 1ns/1ps
module txn_line_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [31:0] cmd_addr = '0;
    logic [63:0] cmd_data = '0;
    logic [31:0] cmd_ip = '0, cmd_sp = '0;
    logic        snp_valid = 1'b0;
    logic [31:0] snp_addr = '0;
    logic        wr_valid, abort_valid, region_open, draining;
    logic [31:0] wr_addr, rb_ip, rb_sp;
    logic [63:0] wr_data;
    logic [2:0]  abort_code;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #2 clk = ~clk;

    txn_line_tracker uut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cmd_ip(cmd_ip), .cmd_sp(cmd_sp),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .abort_valid(abort_valid),
        .abort_code(abort_code), .rb_ip(rb_ip), .rb_sp(rb_sp),
        .region_open(region_open), .draining(draining));

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive one cycle of stimulus, return just after the edge
    task automatic issue(input logic [2:0] op, input logic [31:0] addr, input logic [63:0] dat,
                         input logic snv, input logic [31:0] sna,
                         input logic [31:0] ip, input logic [31:0] sp);
        cmd_op = op; cmd_addr = addr; cmd_data = dat;
        snp_valid = snv; snp_addr = sna; cmd_ip = ip; cmd_sp = sp;
        @(posedge clk); #1;
        cmd_op = 3'd0; snp_valid = 1'b0;
    endtask

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [31:0] addr;
        logic        snv;
        logic [31:0] sna;
        logic        exp_av;
        logic [2:0]  exp_code;
    } row_t;

    // op: 0 none 1 mark 2 acquire 3 store 4 commit 5 abort
    localparam row_t TBL [19] = '{
        '{4'd1, 3'd1, 32'h0000_1000, 1'b0, 32'h0, 1'b0, 3'd0}, // R1 register
        '{4'd2, 3'd1, 32'h0000_1020, 1'b0, 32'h0, 1'b0, 3'd0}, // R2 same line
        '{4'd1, 3'd1, 32'h0000_2000, 1'b0, 32'h0, 1'b0, 3'd0},
        '{4'd3, 3'd2, 32'h0,         1'b0, 32'h0, 1'b0, 3'd0}, // R3 clean acquire
        '{4'd5, 3'd3, 32'h0000_1004, 1'b0, 32'h0, 1'b0, 3'd0}, // R5 store hit
        '{4'd5, 3'd3, 32'h0000_3000, 1'b0, 32'h0, 1'b1, 3'd4}, // R5 stray
        '{4'd1, 3'd1, 32'h0000_4000, 1'b0, 32'h0, 1'b0, 3'd0},
        '{4'd3, 3'd0, 32'h0,         1'b1, 32'h0000_4010, 1'b0, 3'd0}, // R3 disturb
        '{4'd3, 3'd2, 32'h0,         1'b0, 32'h0, 1'b1, 3'd3}, // R3 abort
        '{4'd5, 3'd3, 32'h0000_4000, 1'b0, 32'h0, 1'b1, 3'd4}, // R5 closed store
        '{4'd1, 3'd1, 32'h0000_5000, 1'b0, 32'h0, 1'b0, 3'd0},
        '{4'd6, 3'd2, 32'h0,         1'b0, 32'h0, 1'b0, 3'd0},
        '{4'd6, 3'd0, 32'h0,         1'b1, 32'h0000_5030, 1'b1, 3'd2}, // R6 conflict
        '{4'd1, 3'd1, 32'h0000_6000, 1'b0, 32'h0, 1'b0, 3'd0},
        '{4'd7, 3'd2, 32'h0,         1'b0, 32'h0, 1'b0, 3'd0},
        '{4'd7, 3'd5, 32'h0,         1'b0, 32'h0, 1'b1, 3'd5}, // R7 user abort
        '{4'd7, 3'd0, 32'h0,         1'b1, 32'h0000_6000, 1'b0, 3'd0}, // R7 line gone
        '{4'd7, 3'd2, 32'h0,         1'b0, 32'h0, 1'b0, 3'd0},
        '{4'd7, 3'd5, 32'h0,         1'b0, 32'h0, 1'b1, 3'd5}
    };

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R10 reset state
        check("R10", "region_open", region_open, 0);
        check("R10", "draining", draining, 0);
        check("R10", "wr_valid", wr_valid, 0);
        check("R10", "abort_valid", abort_valid, 0);

        foreach (TBL[i]) begin
            issue(TBL[i].op, TBL[i].addr, 64'(i), TBL[i].snv, TBL[i].sna, 32'h100 + i, 32'h200 + i);
            check($sformatf("R%0d", TBL[i].req), $sformatf("row %0d abort_valid", i), abort_valid, TBL[i].exp_av);
            if (TBL[i].exp_av)
                check($sformatf("R%0d", TBL[i].req), $sformatf("row %0d code", i), abort_code, TBL[i].exp_code);
        end

        // R1 capacity: eight distinct plus a duplicate, then a ninth
        begin
            int seen = 0;
            for (int k = 0; k < 8; k++) begin
                issue(3'd1, 32'h0001_0000 + k * 64, 0, 0, 0, 0, 0);
                seen += abort_valid;
            end
            issue(3'd1, 32'h0001_0008, 0, 0, 0, 0, 0);
            seen += abort_valid;
            check("R1", "aborts while filling", 64'(seen), 0);
        end
        issue(3'd1, 32'h0002_0000, 0, 0, 0, 0, 0);
        check("R1", "ninth abort", abort_valid, 1);
        check("R1", "capacity code", abort_code, 1);
        check("R4", "closed abort rb_ip", rb_ip, 0);
        issue(3'd0, 0, 0, 0, 0, 0, 0);
        check("R4", "pulse width", abort_valid, 0);

        // R4 pointers returned after open-region abort
        issue(3'd1, 32'h0000_D000, 0, 0, 0, 0, 0);
        issue(3'd2, 0, 0, 0, 0, 32'h1234, 32'h5678);
        check("R4", "region open", region_open, 1);
        issue(3'd5, 0, 0, 0, 0, 0, 0);
        check("R4", "rb_ip", rb_ip, 32'h1234);
        check("R4", "rb_sp", rb_sp, 32'h5678);
        // R4 disturbed acquire returns its own pointers
        issue(3'd1, 32'h0000_E000, 0, 0, 0, 0, 0);
        issue(3'd2, 0, 0, 1, 32'h0000_E03C, 32'h77, 32'h88);
        check("R3", "same-cycle snoop code", abort_code, 3);
        check("R4", "disturbed rb_ip", rb_ip, 32'h77);
        check("R4", "disturbed rb_sp", rb_sp, 32'h88);

        // R8 / R2 commit of three lines, middle one clean
        issue(3'd1, 32'h0000_A000, 0, 0, 0, 0, 0);
        issue(3'd1, 32'h0000_B040, 0, 0, 0, 0, 0);
        issue(3'd1, 32'h0000_C080, 0, 0, 0, 0, 0);
        issue(3'd2, 0, 0, 0, 0, 32'h100, 32'h200);
        issue(3'd3, 32'h0000_C0BF, 64'h11, 0, 0, 0, 0);
        issue(3'd3, 32'h0000_A03F, 64'h22, 0, 0, 0, 0);
        issue(3'd3, 32'h0000_A001, 64'h33, 0, 0, 0, 0);
        issue(3'd4, 0, 0, 0, 0, 0, 0);
        check("R8", "draining", draining, 1);
        check("R8", "first wr_valid", wr_valid, 1);
        check("R2", "first wr_addr", wr_addr, 32'h0000_A000);
        check("R5", "first wr_data", wr_data, 64'h33);
        // R9 abort command mid-drain is ignored
        issue(3'd5, 0, 0, 1, 32'h0000_A000, 0, 0);
        check("R9", "no abort in drain", abort_valid, 0);
        check("R8", "clean entry", wr_valid, 0);
        @(posedge clk); #1;
        check("R8", "third wr_valid", wr_valid, 1);
        check("R2", "third wr_addr", wr_addr, 32'h0000_C080);
        check("R8", "third wr_data", wr_data, 64'h11);
        @(posedge clk); #1;
        check("R8", "drain done", draining, 0);
        check("R8", "closed", region_open, 0);
        check("R8", "wr idle", wr_valid, 0);

        // R6 snoop beats a same-cycle commit
        issue(3'd1, 32'h0000_F000, 0, 0, 0, 0, 0);
        issue(3'd2, 0, 0, 0, 0, 0, 0);
        issue(3'd3, 32'h0000_F000, 64'h55, 0, 0, 0, 0);
        issue(3'd4, 0, 0, 1, 32'h0000_F020, 0, 0);
        check("R6", "abort code", abort_code, 2);
        check("R6", "no drain", draining, 0);
        // R7 discarded data never written
        issue(3'd2, 0, 0, 0, 0, 0, 0);
        issue(3'd4, 0, 0, 0, 0, 0, 0);
        check("R7", "empty commit wr_valid", wr_valid, 0);
        check("R7", "empty commit draining", draining, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule